// File: doc/BRIEF.md
# Calendar Clock Timer with Alarm Compare

This block keeps the time of day for a chip. It counts seconds, minutes, hours and days from a one-pulse-per-second tick input. Software controls it through a small byte-wide register port. Three comparison registers hold an alarm time as minute, hour and day. When the running count reaches that time, the block sets a sticky alarm flag. The flag, masked by an enable bit, drives an interrupt line.

The counters have no connection to the system reset, so the time survives a chip-level reset. Software clears the counters with a reset request in the control register. That request takes effect only while the timer is stopped. A single write that asks to start and to clear at the same moment starts the timer and leaves the count unchanged. Software therefore clears the timer first and starts it with a separate write.

Register map (4-bit address, 8-bit data):

| Address | Contents |
|---|---|
| 0 | Control: bit 0 is run, bit 1 is clear request. |
| 1 to 4 | Seconds, minutes, hours and days counters. Read-only. |
| 5 | Minute compare. |
| 6 | Hour compare. |
| 7 | Day compare. |
| 8 | Interrupt: bit 0 is enable, bit 1 is alarm flag. |

Top module: `cal_timer`

## Requirements
- R1: While run (control bit 0) is 1, each clock with `tick` high advances the count. Seconds roll from SEC_PER_MIN-1 to 0 and carry into minutes. Minutes roll from MIN_PER_HOUR-1 to 0 and carry into hours. Hours roll from HOUR_PER_DAY-1 to 0 and carry into days. Days wrap from 2^DAY_W-1 to 0. The counts read back at addresses 1 to 4 one cycle after the tick.
- R2: While run is 0, `tick` leaves all four counters unchanged.
- R3: A write to address 0 with bit 1 = 1 and bit 0 = 0, made while the timer is stopped, clears all four counters in the next cycle.
- R4: While the timer is running, a write to address 0 with bit 1 = 1 leaves the counters unchanged.
- R5: A write to address 0 with both bit 0 and bit 1 set, made while the timer is stopped, starts the timer and does not clear the counters.
- R6: Address 0 reads back the run bit in bit 0, and bit 1 always reads 0. Writing 0 to bit 1 does not change the counters.
- R7: `rstN` low clears run and the interrupt enable. It leaves the four counters unchanged.
- R8: The compare registers are as wide as the counter they match: minute, hour and day widths. A write stores only those low bits, and the upper bits read back as 0. Addresses above 8 read 0.
- R9: The alarm flag (address 8, bit 1) is set in the cycle after either of these events, when the new minute, hour and day all equal their compare values:
  - a seconds rollover into the minute;
  - a clear request taken under R3.
- R10: The alarm flag stays set until software writes address 8 with bit 1 = 1. A write with bit 1 = 0 leaves it set. An alarm set event in the same cycle as a clear write wins, and the flag stays set.
- R11: `irq` is high exactly when the alarm flag and the enable bit (address 8, bit 0) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| tick | input | 1 | One-cycle pulse, once per second |
| wrEn | input | 1 | Write strobe for the register port |
| addr | input | 4 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with these parameters:

| Parameter | Bench value |
|---|---|
| SEC_PER_MIN | 4 |
| MIN_PER_HOUR | 3 |
| HOUR_PER_DAY | 3 |
| DAY_W | 3 |

With these values a full wrap of the day counter takes 288 ticks. Every carry boundary and the final return to zero are therefore reached in a short run.

The narrow compare registers (2, 2 and 3 bits) show truncation on wide writes. The alarm match then fires on small, easily reached times, including the all-zero match caused by a clear request.

// File: rtl/cal_timer_pkg.sv
package cal_timer_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL     = 4'd0;
  localparam logic [ADDR_W-1:0] A_SEC      = 4'd1;
  localparam logic [ADDR_W-1:0] A_MIN      = 4'd2;
  localparam logic [ADDR_W-1:0] A_HOUR     = 4'd3;
  localparam logic [ADDR_W-1:0] A_DAY      = 4'd4;
  localparam logic [ADDR_W-1:0] A_CMP_MIN  = 4'd5;
  localparam logic [ADDR_W-1:0] A_CMP_HOUR = 4'd6;
  localparam logic [ADDR_W-1:0] A_CMP_DAY  = 4'd7;
  localparam logic [ADDR_W-1:0] A_IRQ      = 4'd8;

  // Strobes from control to datapath
  typedef struct packed {
    logic swClear;    // qualified software clear of all counters
    logic advance;    // count one second
    logic ldCmpMin;
    logic ldCmpHour;
    logic ldCmpDay;
  } strobe_t;
endpackage

// File: rtl/cal_timer_ctrl.sv
module cal_timer_ctrl
  import cal_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        wrBits,
  input  logic              alarmEvent,
  output strobe_t           strb,
  output logic              runQ,
  output logic              ienQ,
  output logic              factorQ
);
  logic ctrlWr;
  logic irqWr;

  always_comb begin
    ctrlWr         = wrEn && (addr == A_CTRL);
    irqWr          = wrEn && (addr == A_IRQ);
    // Clear is honoured only when stopped and not starting in the same write
    strb.swClear   = ctrlWr && wrBits[1] && !wrBits[0] && !runQ;
    strb.advance   = tick && runQ;
    strb.ldCmpMin  = wrEn && (addr == A_CMP_MIN);
    strb.ldCmpHour = wrEn && (addr == A_CMP_HOUR);
    strb.ldCmpDay  = wrEn && (addr == A_CMP_DAY);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ <= 1'b0;
      ienQ <= 1'b0;
    end else begin
      if (ctrlWr) runQ <= wrBits[0];
      if (irqWr)  ienQ <= wrBits[0];
    end
  end

  // Alarm flag has no reset; a set event beats a software clear
  always_ff @(posedge clk) begin
    if (alarmEvent)
      factorQ <= 1'b1;
    else if (irqWr && wrBits[1])
      factorQ <= 1'b0;
  end
endmodule

// File: rtl/cal_timer_dp.sv
module cal_timer_dp
  import cal_timer_pkg::*;
#(
  parameter int SEC_PER_MIN  = 60,
  parameter int MIN_PER_HOUR = 60,
  parameter int HOUR_PER_DAY = 24,
  parameter int DAY_W        = 5,
  parameter int SEC_W        = 6,
  parameter int MIN_W        = 6,
  parameter int HOUR_W       = 5,
  parameter int CMP_W        = 6
) (
  input  logic              clk,
  input  strobe_t           strb,
  input  logic [CMP_W-1:0]  cmpData,
  output logic [SEC_W-1:0]  secQ,
  output logic [MIN_W-1:0]  minQ,
  output logic [HOUR_W-1:0] hourQ,
  output logic [DAY_W-1:0]  dayQ,
  output logic [MIN_W-1:0]  cmpMinQ,
  output logic [HOUR_W-1:0] cmpHourQ,
  output logic [DAY_W-1:0]  cmpDayQ,
  output logic              alarmEvent
);
  logic secWrap, minWrap, hourWrap;
  logic minStep, hourStep, dayStep;
  logic [SEC_W-1:0]  secNext;
  logic [MIN_W-1:0]  minNext;
  logic [HOUR_W-1:0] hourNext;
  logic [DAY_W-1:0]  dayNext;
  logic unusedCmp;

  assign unusedCmp = ^cmpData;

  always_comb begin
    secWrap  = secQ  == SEC_W'(SEC_PER_MIN - 1);
    minWrap  = minQ  == MIN_W'(MIN_PER_HOUR - 1);
    hourWrap = hourQ == HOUR_W'(HOUR_PER_DAY - 1);
    minStep  = strb.advance && secWrap;
    hourStep = minStep && minWrap;
    dayStep  = hourStep && hourWrap;

    secNext  = secQ;
    minNext  = minQ;
    hourNext = hourQ;
    dayNext  = dayQ;
    if (strb.swClear) begin
      secNext  = '0;
      minNext  = '0;
      hourNext = '0;
      dayNext  = '0;
    end else begin
      if (strb.advance) secNext  = secWrap  ? '0 : secQ + 1'b1;
      if (minStep)      minNext  = minWrap  ? '0 : minQ + 1'b1;
      if (hourStep)     hourNext = hourWrap ? '0 : hourQ + 1'b1;
      if (dayStep)      dayNext  = dayQ + 1'b1;
    end

    // Alarm is evaluated only when the minute position changes or is cleared
    alarmEvent = (strb.swClear || minStep) && (minNext == cmpMinQ)
                 && (hourNext == cmpHourQ) && (dayNext == cmpDayQ);
  end

  // Counters and compare values deliberately have no reset
  always_ff @(posedge clk) begin
    secQ  <= secNext;
    minQ  <= minNext;
    hourQ <= hourNext;
    dayQ  <= dayNext;
    if (strb.ldCmpMin)  cmpMinQ  <= cmpData[MIN_W-1:0];
    if (strb.ldCmpHour) cmpHourQ <= cmpData[HOUR_W-1:0];
    if (strb.ldCmpDay)  cmpDayQ  <= cmpData[DAY_W-1:0];
  end
endmodule

// File: rtl/cal_timer.sv
module cal_timer
  import cal_timer_pkg::*;
#(
  parameter int SEC_PER_MIN  = 60,
  parameter int MIN_PER_HOUR = 60,
  parameter int HOUR_PER_DAY = 24,
  parameter int DAY_W        = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  localparam int SEC_W  = $clog2(SEC_PER_MIN);
  localparam int MIN_W  = $clog2(MIN_PER_HOUR);
  localparam int HOUR_W = $clog2(HOUR_PER_DAY);
  localparam int CMP_A  = (MIN_W > HOUR_W) ? MIN_W : HOUR_W;
  localparam int CMP_W  = (CMP_A > DAY_W) ? CMP_A : DAY_W;

  strobe_t           strb;
  logic              runQ, ienQ, factorQ, alarmEvent;
  logic [SEC_W-1:0]  secQ;
  logic [MIN_W-1:0]  minQ, cmpMinQ;
  logic [HOUR_W-1:0] hourQ, cmpHourQ;
  logic [DAY_W-1:0]  dayQ, cmpDayQ;
  logic              unusedWr;

  assign unusedWr = ^wrData;

  cal_timer_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tick       (tick),
    .wrEn       (wrEn),
    .addr       (addr),
    .wrBits     (wrData[1:0]),
    .alarmEvent (alarmEvent),
    .strb       (strb),
    .runQ       (runQ),
    .ienQ       (ienQ),
    .factorQ    (factorQ)
  );

  cal_timer_dp #(
    .SEC_PER_MIN  (SEC_PER_MIN),
    .MIN_PER_HOUR (MIN_PER_HOUR),
    .HOUR_PER_DAY (HOUR_PER_DAY),
    .DAY_W        (DAY_W),
    .SEC_W        (SEC_W),
    .MIN_W        (MIN_W),
    .HOUR_W       (HOUR_W),
    .CMP_W        (CMP_W)
  ) u_dp (
    .clk        (clk),
    .strb       (strb),
    .cmpData    (wrData[CMP_W-1:0]),
    .secQ       (secQ),
    .minQ       (minQ),
    .hourQ      (hourQ),
    .dayQ       (dayQ),
    .cmpMinQ    (cmpMinQ),
    .cmpHourQ   (cmpHourQ),
    .cmpDayQ    (cmpDayQ),
    .alarmEvent (alarmEvent)
  );

  always_comb begin
    case (addr)
      A_CTRL:     rdData = DATA_W'(runQ);
      A_SEC:      rdData = DATA_W'(secQ);
      A_MIN:      rdData = DATA_W'(minQ);
      A_HOUR:     rdData = DATA_W'(hourQ);
      A_DAY:      rdData = DATA_W'(dayQ);
      A_CMP_MIN:  rdData = DATA_W'(cmpMinQ);
      A_CMP_HOUR: rdData = DATA_W'(cmpHourQ);
      A_CMP_DAY:  rdData = DATA_W'(cmpDayQ);
      A_IRQ:      rdData = DATA_W'({factorQ, ienQ});
      default:    rdData = '0;
    endcase
  end

  assign irq = factorQ && ienQ;
endmodule

// File: rtl/cal_timer_chk.sv
module cal_timer_chk
  import cal_timer_pkg::*;
#(
  parameter int SEC_PER_MIN = 60,
  parameter int SEC_W       = 6,
  parameter int MIN_W       = 6,
  parameter int HOUR_W      = 5,
  parameter int DAY_W       = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [1:0]        wrBits,
  input logic              runQ,
  input logic              factorQ,
  input logic [SEC_W-1:0]  secQ,
  input logic [MIN_W-1:0]  minQ,
  input logic [HOUR_W-1:0] hourQ,
  input logic [DAY_W-1:0]  dayQ
);
  logic ctrlWr;
  assign ctrlWr = wrEn && (addr == A_CTRL);

  assert_sec_wrap_R1: assert property (@(posedge clk) disable iff (!rstN)
    runQ && tick && secQ == SEC_W'(SEC_PER_MIN - 1) |=> secQ == '0);

  assert_hold_stopped_R2: assert property (@(posedge clk) disable iff (!rstN)
    !runQ && !(ctrlWr && wrBits[1])
    |=> $stable(secQ) && $stable(minQ) && $stable(hourQ) && $stable(dayQ));

  assert_sw_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    !runQ && ctrlWr && wrBits == 2'b10
    |=> secQ == '0 && minQ == '0 && hourQ == '0 && dayQ == '0);

  assert_busy_clear_ignored_R4: assert property (@(posedge clk) disable iff (!rstN)
    runQ && !tick && ctrlWr && wrBits[1]
    |=> $stable(secQ) && $stable(minQ) && $stable(hourQ) && $stable(dayQ));

  assert_start_no_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    !runQ && ctrlWr && wrBits == 2'b11
    |=> runQ && $stable(secQ) && $stable(minQ) && $stable(hourQ) && $stable(dayQ));

  assert_run_after_reset_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !runQ);

  assert_alarm_source_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(factorQ) |-> $past(runQ && tick) || $past(!runQ && ctrlWr && wrBits == 2'b10));

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    factorQ && !(wrEn && addr == A_IRQ && wrBits[1]) |=> factorQ);
endmodule

bind cal_timer cal_timer_chk #(
  .SEC_PER_MIN (SEC_PER_MIN),
  .SEC_W       (SEC_W),
  .MIN_W       (MIN_W),
  .HOUR_W      (HOUR_W),
  .DAY_W       (DAY_W)
) chk (
  .clk     (clk),
  .rstN    (rstN),
  .tick    (tick),
  .wrEn    (wrEn),
  .addr    (addr),
  .wrBits  (wrData[1:0]),
  .runQ    (runQ),
  .factorQ (factorQ),
  .secQ    (secQ),
  .minQ    (minQ),
  .hourQ   (hourQ),
  .dayQ    (dayQ)
);

// File: tb/cal_timer_test.sv
module cal_timer_test;
  localparam int S  = 4;
  localparam int M  = 3;
  localparam int H  = 3;
  localparam int DW = 3;
  localparam int MW = $clog2(M);
  localparam int HW = $clog2(H);

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic       irq;

  int  nChecks = 0;
  int  nErrors = 0;
  bit  done = 0;

  // reference model state
  int mSec = 0, mMin = 0, mHour = 0, mDay = 0;
  int mRun = 0, mIen = 0, mFac = 0;
  int mCmpM = 0, mCmpH = 0, mCmpD = 0;
  bit kCnt = 0, kFac = 0, kCmpM = 0, kCmpH = 0, kCmpD = 0;

  cal_timer #(
    .SEC_PER_MIN  (S),
    .MIN_PER_HOUR (M),
    .HOUR_PER_DAY (H),
    .DAY_W        (DW)
  ) uut (
    .clk    (clk),
    .rstN   (rstN),
    .tick   (tick),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData),
    .rdData (rdData),
    .irq    (irq)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // model update at the active edge
  always @(posedge clk) begin : model
    bit ctlWr, irqWr, clr, carry, hit;
    if (!rstN) begin
      mRun = 0;
      mIen = 0;
    end else begin
      ctlWr = wrEn && addr == 4'd0;
      irqWr = wrEn && addr == 4'd8;
      clr   = ctlWr && wrData[1] && !wrData[0] && mRun == 0;
      carry = 0;
      if (clr) begin
        mSec = 0; mMin = 0; mHour = 0; mDay = 0; kCnt = 1;
      end else if (tick && mRun == 1) begin
        mSec = mSec + 1;
        if (mSec == S) begin
          mSec = 0; carry = 1; mMin = mMin + 1;
          if (mMin == M) begin
            mMin = 0; mHour = mHour + 1;
            if (mHour == H) begin
              mHour = 0; mDay = (mDay + 1) % (1 << DW);
            end
          end
        end
      end
      hit = (clr || carry) && mMin == mCmpM && mHour == mCmpH && mDay == mCmpD;
      if ((clr || carry) && !(kCnt && kCmpM && kCmpH && kCmpD)) kFac = 0;
      else if (hit) begin mFac = 1; kFac = 1; end
      else if (irqWr && wrData[1]) begin mFac = 0; kFac = 1; end
      if (ctlWr) mRun = int'(wrData[0]);
      if (irqWr) mIen = int'(wrData[0]);
      if (wrEn && addr == 4'd5) begin mCmpM = int'(wrData) & ((1 << MW) - 1); kCmpM = 1; end
      if (wrEn && addr == 4'd6) begin mCmpH = int'(wrData) & ((1 << HW) - 1); kCmpH = 1; end
      if (wrEn && addr == 4'd7) begin mCmpD = int'(wrData) & ((1 << DW) - 1); kCmpD = 1; end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin : compare
    int e;
    bit ok;
    string tag;
    if (rstN && !done) begin
      if (mIen == 0) check("R11 irq masked", int'(irq), 0);
      else if (kFac) check("R11 irq", int'(irq), mFac);
      ok = 1;
      e = 0;
      tag = "R8 unmapped";
      case (addr)
        4'd0: begin e = mRun;  tag = "R6 control"; end
        4'd1: begin e = mSec;  ok = kCnt; tag = "R1 seconds"; end
        4'd2: begin e = mMin;  ok = kCnt; tag = "R1 minutes"; end
        4'd3: begin e = mHour; ok = kCnt; tag = "R1 hours"; end
        4'd4: begin e = mDay;  ok = kCnt; tag = "R1 days"; end
        4'd5: begin e = mCmpM; ok = kCmpM; tag = "R8 min compare"; end
        4'd6: begin e = mCmpH; ok = kCmpH; tag = "R8 hour compare"; end
        4'd7: begin e = mCmpD; ok = kCmpD; tag = "R8 day compare"; end
        4'd8: begin e = (mFac << 1) | mIen; ok = kFac; tag = "R10 interrupt reg"; end
        default: ;
      endcase
      if (ok) check(tag, int'(rdData), e);
    end
  end

  task automatic wr(input int a, input int d);
    @(posedge clk); #1;
    wrEn = 1'b1; addr = 4'(a); wrData = 8'(d);
    @(posedge clk); #1;
    wrEn = 1'b0; wrData = 8'd0;
  endtask

  task automatic ticks(input int n);
    @(posedge clk); #1;
    tick = 1'b1;
    repeat (n) @(posedge clk);
    #1 tick = 1'b0;
  endtask

  task automatic expectReg(input int a, input int exp, input string tag);
    @(posedge clk); #1;
    addr = 4'(a);
    @(negedge clk);
    check(tag, int'(rdData), exp);
  endtask

  task automatic expectIrq(input int exp, input string tag);
    @(negedge clk);
    check(tag, int'(irq), exp);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      nErrors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // reset state
    expectReg(0, 0, "R7 run after reset");
    expectReg(8, 0, "R7 enable after reset");
    expectIrq(0, "R11 irq after reset");

    // compare register widths
    wr(5, 8'hFF); expectReg(5, 3, "R8 min compare width");
    wr(6, 8'hFF); expectReg(6, 3, "R8 hour compare width");
    wr(7, 8'hFF); expectReg(7, 7, "R8 day compare width");
    expectReg(9, 0, "R8 unmapped address");

    // alarm at minute 1, hour 0, day 0
    wr(5, 1); wr(6, 0); wr(7, 0);
    wr(8, 8'h02);
    wr(0, 8'h02);
    expectReg(1, 0, "R3 seconds cleared");
    expectReg(2, 0, "R3 minutes cleared");
    expectReg(3, 0, "R3 hours cleared");
    expectReg(4, 0, "R3 days cleared");
    expectReg(8, 0, "R9 no match on clear");

    ticks(5);
    expectReg(1, 0, "R2 stopped ignores tick");

    wr(0, 1);
    ticks(3);
    expectReg(1, 3, "R1 seconds count");
    ticks(1);
    expectReg(1, 0, "R1 seconds wrap");
    expectReg(2, 1, "R1 minute carry");
    expectReg(8, 2, "R9 alarm on minute match");
    expectIrq(0, "R11 masked while disabled");
    wr(8, 1);
    expectReg(8, 3, "R10 flag kept on write of 0");
    expectIrq(1, "R11 irq asserted");
    wr(8, 3);
    expectReg(8, 1, "R10 flag cleared");
    expectIrq(0, "R11 irq dropped");

    // clear request while running
    ticks(2);
    wr(0, 3);
    expectReg(1, 2, "R4 clear ignored while running");
    expectReg(2, 1, "R4 minutes kept");

    // stop, then start and clear in one write
    wr(0, 0);
    wr(0, 3);
    expectReg(0, 1, "R5 started, R6 clear bit reads 0");
    expectReg(1, 2, "R5 seconds not cleared");

    // run to the last second of the last day, then wrap
    ticks(281);
    expectReg(4, 7, "R1 last day");
    expectReg(3, 2, "R1 last hour");
    expectReg(2, 2, "R1 last minute");
    ticks(1);
    expectReg(1, 0, "R1 seconds after day wrap");
    expectReg(2, 0, "R1 minutes after day wrap");
    expectReg(3, 0, "R1 hours after day wrap");
    expectReg(4, 0, "R1 days wrap");

    // pass through the alarm time again
    ticks(5);
    expectReg(8, 3, "R9 alarm on second pass");
    expectIrq(1, "R11 irq on second pass");
    wr(0, 0);
    wr(0, 0);
    expectReg(1, 1, "R6 write of 0 keeps seconds");
    expectReg(2, 1, "R6 write of 0 keeps minutes");

    // clear request producing a zero match
    wr(5, 0);
    wr(8, 3);
    expectIrq(0, "R10 flag cleared before zero match");
    wr(0, 2);
    expectReg(8, 3, "R9 alarm from clear request");
    expectIrq(1, "R11 irq from clear request");

    // system reset keeps the count
    wr(8, 2);
    wr(0, 1);
    ticks(7);
    @(posedge clk); #1 rstN = 1'b0;
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
    expectReg(0, 0, "R7 run cleared by reset");
    expectReg(1, 3, "R7 seconds survive reset");
    expectReg(2, 1, "R7 minutes survive reset");
    expectReg(8, 0, "R7 enable cleared by reset");

    repeat (3) @(posedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule